// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes a 32-bit instruction word, decides whether it is a floating-point arithmetic/convert operation or a floating-point compare, and breaks it into the parts an execution unit needs. It reports the 9-bit operation field and an operation kind. It gives an operand size for the destination and for each of the two sources, and it passes on the three 5-bit register numbers. It also returns a verdict: the word is good, it names a register that its operand size does not allow, or it is not a recognised operation.

The word is presented with a one-cycle `in_valid` strobe. On the next clock edge every result is captured into output registers and `out_valid` goes high for one cycle. The results stay unchanged until the next strobe. A register violation reports trap code 6 on `out_trap`. An unrecognised word reports `out_unknown` with trap code 0. Both cases raise `out_fail`.

The control is a two-state machine. `ST_IDLE` means no result is being shown, and `ST_SHOW` means a fresh result is on the outputs. The transitions are `IDLE->SHOW` and `SHOW->SHOW` on a strobe, and `SHOW->IDLE` and `IDLE->IDLE` without one.

Top module: `fp_op_decoder`

## Requirements
- R1: Group encoding on `out_group`: 1 when `(insn & 0xC1F80000) == 0x81A00000` (arithmetic/convert), 2 when the masked value is `0x81A80000` (compare), 0 otherwise. A word in group 0 is always unknown.
- R2: `out_opf` = insn[13:5], `out_rs1` = insn[18:14], `out_rs2` = insn[4:0], `out_rd` = insn[29:25]. These are reported for every strobed word, including failed ones.
- R3: Size codes are none=0, single=1, double=2, quad=3, raw=4. Kind codes are none=0, add=1, sub=2, mul=3, div=4, sqrt=5, move=6, abs=7, neg=8, convert=9, compare=10, signalling compare=11. In group 1, add/sub/mul/div use codes 0x041/0x045/0x049/0x04D for single, +1 for double and +2 for quad, and give the same size to all three operands. sqrt (0x029/0x02A/0x02B) has no rs1. The widening multiplies are 0x069 (single sources to a double rd) and 0x06E (double sources to a quad rd).
- R4: An operand whose size is double and whose register number has bit 0 set gives trap 6 and fail.
- R5: An operand whose size is quad and whose register number has a nonzero bits 1:0 gives trap 6 and fail.
- R6: Compares (group 2) are 0x051/0x052/0x053 and the signalling forms 0x055/0x056/0x057, for single/double/quad sources. Their rd size is none. Any nonzero rd gives trap 6 and fail.
- R7: An opcode that is missing from its group's table, or a word in group 0, gives `out_unknown`=1, `out_fail`=1 and trap 0, with kind and all sizes set to none.
- R8: Move (0x001), negate (0x005) and absolute (0x009) have rd and rs2 size raw and rs1 size none. Raw operands have no alignment rule.
- R9: `out_valid` is high in exactly the cycle after a strobe. When there is no strobe, all result outputs keep their values.
- R10: After reset, `out_valid` is 0 and `out_trap` is 0.
- R11: The conversions use these sizes (rd, rs2): 0x0C4 (single, raw), 0x0C8 (double, raw), 0x0CC (quad, raw), 0x0D1 (raw, single), 0x0D2 (raw, double), 0x0D3 (raw, quad), 0x0C9 (double, single), 0x0CD (quad, single), 0x0C6 (single, double), 0x0CE (quad, double), 0x0C7 (single, quad), 0x0CB (double, quad). rs1 is none. A good word gives trap 0 and fail 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: capture and decode `in_insn` |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Result captured in the previous cycle |
| out_group | output | 2 | Operate group (0 none, 1 arithmetic, 2 compare) |
| out_kind | output | 4 | Operation kind code |
| out_opf | output | 9 | Operation field |
| out_rd | output | 5 | Destination register number |
| out_rs1 | output | 5 | First source register number |
| out_rs2 | output | 5 | Second source register number |
| out_sz_rd | output | 3 | Destination size code |
| out_sz_rs1 | output | 3 | First source size code |
| out_sz_rs2 | output | 3 | Second source size code |
| out_trap | output | 3 | Trap code (6 for a bad register, else 0) |
| out_unknown | output | 1 | Word not recognised |
| out_fail | output | 1 | Word rejected for any reason |

## Verification
The bench places odd register numbers on double operands and numbers that are 2 modulo 4 on quad operands. A decoder that checked only one bit, or checked the wrong field, would pass a bad word or reject a good one. The widening multiplies and the conversions mix sizes inside one word, so a design that applied a single size to all operands would reject legal words. A compare with a nonzero rd must fail, while the same register number on a destination that is not a compare must pass. Opcodes placed in the wrong group, and words outside both groups, must come back unknown with trap 0, so a design that decoded the operation field without the group would report them as valid.

// File: rtl/fp_op_decoder_pkg.sv
package fp_op_decoder_pkg;

    typedef enum logic [2:0] {
        SZ_NONE = 3'd0,
        SZ_SGL  = 3'd1,
        SZ_DBL  = 3'd2,
        SZ_QUAD = 3'd3,
        SZ_RAW  = 3'd4
    } fpd_size_e;

    typedef enum logic [3:0] {
        K_NONE = 4'd0,
        K_ADD  = 4'd1,
        K_SUB  = 4'd2,
        K_MUL  = 4'd3,
        K_DIV  = 4'd4,
        K_SQRT = 4'd5,
        K_MOVE = 4'd6,
        K_ABS  = 4'd7,
        K_NEG  = 4'd8,
        K_CVT  = 4'd9,
        K_CMP  = 4'd10,
        K_CMPX = 4'd11
    } fpd_kind_e;

    typedef enum logic [1:0] {
        G_NONE  = 2'd0,
        G_ARITH = 2'd1,
        G_CMP   = 2'd2
    } fpd_group_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fpd_state_e;

    localparam logic [31:0] GROUP_MASK  = 32'hC1F8_0000;
    localparam logic [31:0] MATCH_ARITH = 32'h81A0_0000;
    localparam logic [31:0] MATCH_CMP   = 32'h81A8_0000;
    localparam logic [2:0]  TRAP_BADREG = 3'd6;

    localparam logic [8:0] OPC_MOV_S  = 9'h001;
    localparam logic [8:0] OPC_NEG_S  = 9'h005;
    localparam logic [8:0] OPC_ABS_S  = 9'h009;
    localparam logic [8:0] OPC_SQRT_S = 9'h029;
    localparam logic [8:0] OPC_SQRT_D = 9'h02A;
    localparam logic [8:0] OPC_SQRT_Q = 9'h02B;
    localparam logic [8:0] OPC_ADD_S  = 9'h041;
    localparam logic [8:0] OPC_ADD_D  = 9'h042;
    localparam logic [8:0] OPC_ADD_Q  = 9'h043;
    localparam logic [8:0] OPC_SUB_S  = 9'h045;
    localparam logic [8:0] OPC_SUB_D  = 9'h046;
    localparam logic [8:0] OPC_SUB_Q  = 9'h047;
    localparam logic [8:0] OPC_MUL_S  = 9'h049;
    localparam logic [8:0] OPC_MUL_D  = 9'h04A;
    localparam logic [8:0] OPC_MUL_Q  = 9'h04B;
    localparam logic [8:0] OPC_DIV_S  = 9'h04D;
    localparam logic [8:0] OPC_DIV_D  = 9'h04E;
    localparam logic [8:0] OPC_DIV_Q  = 9'h04F;
    localparam logic [8:0] OPC_WMUL_D = 9'h069;
    localparam logic [8:0] OPC_WMUL_Q = 9'h06E;
    localparam logic [8:0] OPC_I2S    = 9'h0C4;
    localparam logic [8:0] OPC_D2S    = 9'h0C6;
    localparam logic [8:0] OPC_Q2S    = 9'h0C7;
    localparam logic [8:0] OPC_I2D    = 9'h0C8;
    localparam logic [8:0] OPC_S2D    = 9'h0C9;
    localparam logic [8:0] OPC_Q2D    = 9'h0CB;
    localparam logic [8:0] OPC_I2Q    = 9'h0CC;
    localparam logic [8:0] OPC_S2Q    = 9'h0CD;
    localparam logic [8:0] OPC_D2Q    = 9'h0CE;
    localparam logic [8:0] OPC_S2I    = 9'h0D1;
    localparam logic [8:0] OPC_D2I    = 9'h0D2;
    localparam logic [8:0] OPC_Q2I    = 9'h0D3;
    localparam logic [8:0] OPC_CMP_S  = 9'h051;
    localparam logic [8:0] OPC_CMP_D  = 9'h052;
    localparam logic [8:0] OPC_CMP_Q  = 9'h053;
    localparam logic [8:0] OPC_CMPX_S = 9'h055;
    localparam logic [8:0] OPC_CMPX_D = 9'h056;
    localparam logic [8:0] OPC_CMPX_Q = 9'h057;

endpackage

// File: rtl/fp_op_group_sel.sv
module fp_op_group_sel
    import fp_op_decoder_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output fpd_group_e        grp
);

    logic [INSN_W-1:0] masked;

    always_comb begin
        masked = insn & GROUP_MASK[INSN_W-1:0];
        if (masked == MATCH_ARITH[INSN_W-1:0]) begin
            grp = G_ARITH;
        end else if (masked == MATCH_CMP[INSN_W-1:0]) begin
            grp = G_CMP;
        end else begin
            grp = G_NONE;
        end
    end

endmodule

// File: rtl/fp_op_table.sv
module fp_op_table
    import fp_op_decoder_pkg::*;
#(
    parameter int OPF_W = 9
) (
    input  fpd_group_e       grp,
    input  logic [OPF_W-1:0] opf,
    output logic             known,
    output fpd_kind_e        kind,
    output fpd_size_e        sz_rd,
    output fpd_size_e        sz_rs1,
    output fpd_size_e        sz_rs2
);

    logic [8:0] code;

    always_comb begin
        code   = 9'(opf);
        known  = 1'b1;
        kind   = K_NONE;
        sz_rd  = SZ_NONE;
        sz_rs1 = SZ_NONE;
        sz_rs2 = SZ_NONE;
        if (grp == G_ARITH) begin
            case (code)
                OPC_ADD_S, OPC_SUB_S, OPC_MUL_S, OPC_DIV_S: begin
                    sz_rd = SZ_SGL; sz_rs1 = SZ_SGL; sz_rs2 = SZ_SGL;
                end
                OPC_ADD_D, OPC_SUB_D, OPC_MUL_D, OPC_DIV_D: begin
                    sz_rd = SZ_DBL; sz_rs1 = SZ_DBL; sz_rs2 = SZ_DBL;
                end
                OPC_ADD_Q, OPC_SUB_Q, OPC_MUL_Q, OPC_DIV_Q: begin
                    sz_rd = SZ_QUAD; sz_rs1 = SZ_QUAD; sz_rs2 = SZ_QUAD;
                end
                OPC_WMUL_D: begin
                    sz_rd = SZ_DBL; sz_rs1 = SZ_SGL; sz_rs2 = SZ_SGL;
                end
                OPC_WMUL_Q: begin
                    sz_rd = SZ_QUAD; sz_rs1 = SZ_DBL; sz_rs2 = SZ_DBL;
                end
                OPC_SQRT_S: begin sz_rd = SZ_SGL;  sz_rs2 = SZ_SGL;  end
                OPC_SQRT_D: begin sz_rd = SZ_DBL;  sz_rs2 = SZ_DBL;  end
                OPC_SQRT_Q: begin sz_rd = SZ_QUAD; sz_rs2 = SZ_QUAD; end
                OPC_MOV_S, OPC_NEG_S, OPC_ABS_S: begin
                    sz_rd = SZ_RAW; sz_rs2 = SZ_RAW;
                end
                OPC_I2S: begin sz_rd = SZ_SGL;  sz_rs2 = SZ_RAW;  end
                OPC_I2D: begin sz_rd = SZ_DBL;  sz_rs2 = SZ_RAW;  end
                OPC_I2Q: begin sz_rd = SZ_QUAD; sz_rs2 = SZ_RAW;  end
                OPC_S2I: begin sz_rd = SZ_RAW;  sz_rs2 = SZ_SGL;  end
                OPC_D2I: begin sz_rd = SZ_RAW;  sz_rs2 = SZ_DBL;  end
                OPC_Q2I: begin sz_rd = SZ_RAW;  sz_rs2 = SZ_QUAD; end
                OPC_S2D: begin sz_rd = SZ_DBL;  sz_rs2 = SZ_SGL;  end
                OPC_S2Q: begin sz_rd = SZ_QUAD; sz_rs2 = SZ_SGL;  end
                OPC_D2S: begin sz_rd = SZ_SGL;  sz_rs2 = SZ_DBL;  end
                OPC_D2Q: begin sz_rd = SZ_QUAD; sz_rs2 = SZ_DBL;  end
                OPC_Q2S: begin sz_rd = SZ_SGL;  sz_rs2 = SZ_QUAD; end
                OPC_Q2D: begin sz_rd = SZ_DBL;  sz_rs2 = SZ_QUAD; end
                default: known = 1'b0;
            endcase
            case (code)
                OPC_ADD_S, OPC_ADD_D, OPC_ADD_Q:             kind = K_ADD;
                OPC_SUB_S, OPC_SUB_D, OPC_SUB_Q:             kind = K_SUB;
                OPC_MUL_S, OPC_MUL_D, OPC_MUL_Q,
                OPC_WMUL_D, OPC_WMUL_Q:                      kind = K_MUL;
                OPC_DIV_S, OPC_DIV_D, OPC_DIV_Q:             kind = K_DIV;
                OPC_SQRT_S, OPC_SQRT_D, OPC_SQRT_Q:          kind = K_SQRT;
                OPC_MOV_S:                                   kind = K_MOVE;
                OPC_ABS_S:                                   kind = K_ABS;
                OPC_NEG_S:                                   kind = K_NEG;
                OPC_I2S, OPC_I2D, OPC_I2Q, OPC_S2I, OPC_D2I,
                OPC_Q2I, OPC_S2D, OPC_S2Q, OPC_D2S, OPC_D2Q,
                OPC_Q2S, OPC_Q2D:                            kind = K_CVT;
                default:                                     kind = K_NONE;
            endcase
        end else if (grp == G_CMP) begin
            case (code)
                OPC_CMP_S:  begin kind = K_CMP;  sz_rs1 = SZ_SGL;  sz_rs2 = SZ_SGL;  end
                OPC_CMP_D:  begin kind = K_CMP;  sz_rs1 = SZ_DBL;  sz_rs2 = SZ_DBL;  end
                OPC_CMP_Q:  begin kind = K_CMP;  sz_rs1 = SZ_QUAD; sz_rs2 = SZ_QUAD; end
                OPC_CMPX_S: begin kind = K_CMPX; sz_rs1 = SZ_SGL;  sz_rs2 = SZ_SGL;  end
                OPC_CMPX_D: begin kind = K_CMPX; sz_rs1 = SZ_DBL;  sz_rs2 = SZ_DBL;  end
                OPC_CMPX_Q: begin kind = K_CMPX; sz_rs1 = SZ_QUAD; sz_rs2 = SZ_QUAD; end
                default:    known = 1'b0;
            endcase
        end else begin
            known = 1'b0;
        end
        if (!known) begin
            kind   = K_NONE;
            sz_rd  = SZ_NONE;
            sz_rs1 = SZ_NONE;
            sz_rs2 = SZ_NONE;
        end
    end

endmodule

// File: rtl/fp_op_regchk.sv
module fp_op_regchk
    import fp_op_decoder_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  fpd_size_e        size,
    input  logic [IDX_W-1:0] idx,
    input  logic             cc_dest,
    output logic             bad
);

    always_comb begin
        unique case (size)
            SZ_DBL:  bad = idx[0];
            SZ_QUAD: bad = |idx[1:0];
            SZ_NONE: bad = cc_dest && (|idx);
            default: bad = 1'b0;
        endcase
    end

endmodule

// File: rtl/fp_op_decoder.sv
module fp_op_decoder
    import fp_op_decoder_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5,
    parameter int OPF_W  = 9,
    parameter int TRAP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    output logic              out_valid,
    output logic [1:0]        out_group,
    output logic [3:0]        out_kind,
    output logic [OPF_W-1:0]  out_opf,
    output logic [IDX_W-1:0]  out_rd,
    output logic [IDX_W-1:0]  out_rs1,
    output logic [IDX_W-1:0]  out_rs2,
    output logic [2:0]        out_sz_rd,
    output logic [2:0]        out_sz_rs1,
    output logic [2:0]        out_sz_rs2,
    output logic [TRAP_W-1:0] out_trap,
    output logic              out_unknown,
    output logic              out_fail
);

    localparam int RS2_LO  = 0;
    localparam int OPF_LO  = RS2_LO + IDX_W;
    localparam int RS1_LO  = OPF_LO + OPF_W;
    localparam int GRP_W   = 6;
    localparam int RD_LO   = RS1_LO + IDX_W + GRP_W;
    localparam int N_SLOTS = 3;

    fpd_group_e             grp;
    logic                   known;
    fpd_kind_e              kind;
    fpd_size_e              sz_rd, sz_rs1, sz_rs2;
    logic [OPF_W-1:0]       f_opf;
    logic [IDX_W-1:0]       f_rd, f_rs1, f_rs2;
    fpd_size_e              slot_sz  [N_SLOTS];
    logic [IDX_W-1:0]       slot_idx [N_SLOTS];
    logic [N_SLOTS-1:0]     slot_bad;
    logic                   is_cmp;
    logic                   any_bad;
    logic [TRAP_W-1:0]      trap_nx;
    fpd_state_e             state_q, state_d;

    assign f_opf  = in_insn[OPF_LO +: OPF_W];
    assign f_rs1  = in_insn[RS1_LO +: IDX_W];
    assign f_rs2  = in_insn[RS2_LO +: IDX_W];
    assign f_rd   = in_insn[RD_LO  +: IDX_W];
    assign is_cmp = (grp == G_CMP);

    fp_op_group_sel #(.INSN_W(INSN_W)) u_grp (
        .insn (in_insn),
        .grp  (grp)
    );

    fp_op_table #(.OPF_W(OPF_W)) u_tab (
        .grp    (grp),
        .opf    (f_opf),
        .known  (known),
        .kind   (kind),
        .sz_rd  (sz_rd),
        .sz_rs1 (sz_rs1),
        .sz_rs2 (sz_rs2)
    );

    // slot 0 = destination, slot 1 = first source, slot 2 = second source
    always_comb begin
        slot_sz[0]  = sz_rd;   slot_idx[0] = f_rd;
        slot_sz[1]  = sz_rs1;  slot_idx[1] = f_rs1;
        slot_sz[2]  = sz_rs2;  slot_idx[2] = f_rs2;
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        fp_op_regchk #(.IDX_W(IDX_W)) u_chk (
            .size    (slot_sz[s]),
            .idx     (slot_idx[s]),
            .cc_dest ((s == 0) ? is_cmp : 1'b0),
            .bad     (slot_bad[s])
        );
    end

    assign any_bad = known && (|slot_bad);
    assign trap_nx = any_bad ? TRAP_W'(TRAP_BADREG) : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign out_valid = (state_q == ST_SHOW);

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_group   <= '0;
            out_kind    <= '0;
            out_opf     <= '0;
            out_rd      <= '0;
            out_rs1     <= '0;
            out_rs2     <= '0;
            out_sz_rd   <= '0;
            out_sz_rs1  <= '0;
            out_sz_rs2  <= '0;
            out_trap    <= '0;
            out_unknown <= 1'b0;
            out_fail    <= 1'b0;
        end else if (in_valid) begin
            out_group   <= grp;
            out_kind    <= kind;
            out_opf     <= f_opf;
            out_rd      <= f_rd;
            out_rs1     <= f_rs1;
            out_rs2     <= f_rs2;
            out_sz_rd   <= sz_rd;
            out_sz_rs1  <= sz_rs1;
            out_sz_rs2  <= sz_rs2;
            out_trap    <= trap_nx;
            out_unknown <= !known;
            out_fail    <= any_bad || !known;
        end
    end

endmodule

// File: rtl/fp_op_decoder_chk.sv
module fp_op_decoder_chk
    import fp_op_decoder_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5,
    parameter int OPF_W  = 9,
    parameter int TRAP_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [INSN_W-1:0] in_insn,
    input logic              out_valid,
    input logic [1:0]        out_group,
    input logic [3:0]        out_kind,
    input logic [OPF_W-1:0]  out_opf,
    input logic [IDX_W-1:0]  out_rd,
    input logic [IDX_W-1:0]  out_rs1,
    input logic [IDX_W-1:0]  out_rs2,
    input logic [2:0]        out_sz_rd,
    input logic [2:0]        out_sz_rs1,
    input logic [2:0]        out_sz_rs2,
    input logic [TRAP_W-1:0] out_trap,
    input logic              out_unknown,
    input logic              out_fail
);

    assert_group_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_insn & GROUP_MASK[INSN_W-1:0]) == MATCH_ARITH[INSN_W-1:0])
                 && (in_insn[13:5] == 9'h041)
        |=> out_group == 2'd1 && out_kind == 4'd1);

    assert_no_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_insn[31:30] != 2'b10) |=> out_group == 2'd0 && out_unknown);

    assert_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_rs2 == $past(in_insn[4:0]) && out_rs1 == $past(in_insn[18:14])
                  && out_rd == $past(in_insn[29:25]) && out_opf == $past(in_insn[13:5]));

    assert_dbl_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fail |-> !((out_sz_rd == 3'd2 && out_rd[0]) ||
                                     (out_sz_rs1 == 3'd2 && out_rs1[0]) ||
                                     (out_sz_rs2 == 3'd2 && out_rs2[0])));

    assert_quad_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fail |-> !((out_sz_rd == 3'd3 && out_rd[1:0] != 2'd0) ||
                                     (out_sz_rs1 == 3'd3 && out_rs1[1:0] != 2'd0) ||
                                     (out_sz_rs2 == 3'd3 && out_rs2[1:0] != 2'd0)));

    assert_cc_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_group == 2'd2 && !out_fail |-> out_rd == '0 && out_sz_rd == 3'd0);

    assert_trap_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_trap == '0) || (out_trap == TRAP_W'(6)));

    assert_unknown_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_unknown |-> out_fail && out_trap == '0 && out_kind == '0
                                     && out_sz_rd == '0 && out_sz_rs1 == '0 && out_sz_rs2 == '0);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_opf) && $stable(out_trap) && $stable(out_fail)
                      && $stable(out_sz_rs2) && $stable(out_kind));

endmodule

bind fp_op_decoder fp_op_decoder_chk #(
    .INSN_W(INSN_W), .IDX_W(IDX_W), .OPF_W(OPF_W), .TRAP_W(TRAP_W)
) u_props (.*);

// File: tb/fp_op_decoder_test.sv
`timescale 1ns/1ps
module fp_op_decoder_test;

    typedef struct packed {
        logic [1:0] grp;
        logic [3:0] kind;
        logic [8:0] opf;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic [2:0] szd;
        logic [2:0] sz1;
        logic [2:0] sz2;
        logic [2:0] trap;
        logic       unk;
        logic       fail;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic        out_valid;
    logic [1:0]  out_group;
    logic [3:0]  out_kind;
    logic [8:0]  out_opf;
    logic [4:0]  out_rd, out_rs1, out_rs2;
    logic [2:0]  out_sz_rd, out_sz_rs1, out_sz_rs2;
    logic [2:0]  out_trap;
    logic        out_unknown, out_fail;

    int checks = 0;
    int errors = 0;
    res_t  exp_q[$];
    string tag_q[$];
    res_t  last_seen;
    logic  have_last = 1'b0;
    logic  mon_on = 1'b0;

    always #5 clk = ~clk;

    fp_op_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .out_valid(out_valid), .out_group(out_group), .out_kind(out_kind),
        .out_opf(out_opf), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
        .out_sz_rd(out_sz_rd), .out_sz_rs1(out_sz_rs1), .out_sz_rs2(out_sz_rs2),
        .out_trap(out_trap), .out_unknown(out_unknown), .out_fail(out_fail)
    );

    function automatic logic [31:0] mk(input int g, input logic [8:0] op,
                                       input logic [4:0] rd, input logic [4:0] a,
                                       input logic [4:0] b);
        logic [5:0] mid;
        mid = (g == 2) ? 6'b110101 : 6'b110100;
        return {2'b10, rd, mid, a, op, b};
    endfunction

    function automatic logic misal(input logic [2:0] sz, input logic [4:0] r);
        if (sz == 3'd2) return r[0];
        if (sz == 3'd3) return r[1:0] != 2'd0;
        return 1'b0;
    endfunction

    // reference model built from the requirement list
    function automatic res_t model(input logic [31:0] w);
        res_t e;
        logic ok;
        logic [2:0] d, a, b;
        logic [3:0] k;
        e = '0;
        ok = 1'b1; d = 0; a = 0; b = 0; k = 0;
        if ((w & 32'hC1F80000) == 32'h81A00000) e.grp = 2'd1;
        else if ((w & 32'hC1F80000) == 32'h81A80000) e.grp = 2'd2;
        e.opf = w[13:5]; e.rd = w[29:25]; e.rs1 = w[18:14]; e.rs2 = w[4:0];
        if (e.grp == 2'd1) begin
            case (e.opf)
                9'h041: begin k=1; d=1; a=1; b=1; end
                9'h042: begin k=1; d=2; a=2; b=2; end
                9'h043: begin k=1; d=3; a=3; b=3; end
                9'h045: begin k=2; d=1; a=1; b=1; end
                9'h046: begin k=2; d=2; a=2; b=2; end
                9'h047: begin k=2; d=3; a=3; b=3; end
                9'h049: begin k=3; d=1; a=1; b=1; end
                9'h04A: begin k=3; d=2; a=2; b=2; end
                9'h04B: begin k=3; d=3; a=3; b=3; end
                9'h04D: begin k=4; d=1; a=1; b=1; end
                9'h04E: begin k=4; d=2; a=2; b=2; end
                9'h04F: begin k=4; d=3; a=3; b=3; end
                9'h069: begin k=3; d=2; a=1; b=1; end
                9'h06E: begin k=3; d=3; a=2; b=2; end
                9'h029: begin k=5; d=1; b=1; end
                9'h02A: begin k=5; d=2; b=2; end
                9'h02B: begin k=5; d=3; b=3; end
                9'h001: begin k=6; d=4; b=4; end
                9'h009: begin k=7; d=4; b=4; end
                9'h005: begin k=8; d=4; b=4; end
                9'h0C4: begin k=9; d=1; b=4; end
                9'h0C8: begin k=9; d=2; b=4; end
                9'h0CC: begin k=9; d=3; b=4; end
                9'h0D1: begin k=9; d=4; b=1; end
                9'h0D2: begin k=9; d=4; b=2; end
                9'h0D3: begin k=9; d=4; b=3; end
                9'h0C9: begin k=9; d=2; b=1; end
                9'h0CD: begin k=9; d=3; b=1; end
                9'h0C6: begin k=9; d=1; b=2; end
                9'h0CE: begin k=9; d=3; b=2; end
                9'h0C7: begin k=9; d=1; b=3; end
                9'h0CB: begin k=9; d=2; b=3; end
                default: ok = 1'b0;
            endcase
        end else if (e.grp == 2'd2) begin
            case (e.opf)
                9'h051: begin k=10; a=1; b=1; end
                9'h052: begin k=10; a=2; b=2; end
                9'h053: begin k=10; a=3; b=3; end
                9'h055: begin k=11; a=1; b=1; end
                9'h056: begin k=11; a=2; b=2; end
                9'h057: begin k=11; a=3; b=3; end
                default: ok = 1'b0;
            endcase
        end else begin
            ok = 1'b0;
        end
        if (!ok) begin
            e.unk = 1'b1; e.fail = 1'b1;
        end else begin
            e.kind = k; e.szd = d; e.sz1 = a; e.sz2 = b;
            if (misal(a, e.rs1) || misal(b, e.rs2) ||
                ((e.grp == 2'd2) ? (e.rd != 5'd0) : misal(d, e.rd))) begin
                e.trap = 3'd6; e.fail = 1'b1;
            end
        end
        return e;
    endfunction

    function automatic res_t actual();
        res_t r;
        r = {out_group, out_kind, out_opf, out_rd, out_rs1, out_rs2,
             out_sz_rd, out_sz_rs1, out_sz_rs2, out_trap, out_unknown, out_fail};
        return r;
    endfunction

    // driver
    task automatic send(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = w;
        exp_q.push_back(model(w));
        tag_q.push_back(tag);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9: out_valid high with no word pending, actual=1 expected=0");
                end else begin
                    res_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (actual() !== e) begin
                        errors++;
                        $display("FAIL %s: insn result actual=%h expected=%h", t, actual(), e);
                    end
                    last_seen = e;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                checks++;
                if (actual() !== last_seen) begin
                    errors++;
                    $display("FAIL R9: outputs changed while idle, actual=%h expected=%h",
                             actual(), last_seen);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_trap !== 3'd0) begin
            errors++;
            $display("FAIL R10: reset state actual=%b/%0d expected=0/0", out_valid, out_trap);
        end
        mon_on = 1'b1;

        // R1 R2 R3: arithmetic, each size, aligned registers
        send(mk(1, 9'h041, 5'd3, 5'd7, 5'd9),   "R3 add single");
        send(mk(1, 9'h046, 5'd4, 5'd6, 5'd8),   "R3 sub double");
        send(mk(1, 9'h04B, 5'd8, 5'd12, 5'd28), "R3 mul quad");
        send(mk(1, 9'h04D, 5'd1, 5'd2, 5'd31),  "R2 div single fields");
        idle(2);
        send(mk(1, 9'h069, 5'd2, 5'd3, 5'd5),   "R3 widening mul single->double");
        send(mk(1, 9'h06E, 5'd4, 5'd2, 5'd6),   "R3 widening mul double->quad");
        send(mk(1, 9'h02B, 5'd0, 5'd17, 5'd4),  "R3 sqrt quad ignores rs1");
        // R4: double alignment
        send(mk(1, 9'h042, 5'd2, 5'd3, 5'd4),   "R4 odd rs1 double");
        send(mk(1, 9'h042, 5'd5, 5'd2, 5'd4),   "R4 odd rd double");
        send(mk(1, 9'h04E, 5'd2, 5'd2, 5'd9),   "R4 odd rs2 double");
        // R5: quad alignment
        send(mk(1, 9'h043, 5'd4, 5'd8, 5'd2),   "R5 rs2=2 quad");
        send(mk(1, 9'h047, 5'd6, 5'd0, 5'd4),   "R5 rd=6 quad");
        send(mk(1, 9'h0CE, 5'd4, 5'd0, 5'd3),   "R4 convert double source odd");
        idle(3);
        // R6: compares
        send(mk(2, 9'h051, 5'd0, 5'd3, 5'd5),   "R6 compare single rd=0");
        send(mk(2, 9'h052, 5'd1, 5'd2, 5'd4),   "R6 compare double rd=1");
        send(mk(2, 9'h057, 5'd0, 5'd4, 5'd8),   "R6 signalling compare quad");
        send(mk(2, 9'h056, 5'd0, 5'd1, 5'd4),   "R6 compare double odd rs1");
        // R7: unknown
        send(mk(1, 9'h0FF, 5'd1, 5'd1, 5'd1),   "R7 missing opcode group 1");
        send(mk(1, 9'h051, 5'd0, 5'd1, 5'd1),   "R7 compare code in group 1");
        send(mk(2, 9'h041, 5'd0, 5'd0, 5'd0),   "R7 add code in group 2");
        send(32'h0000_0000,                     "R1 R7 no group zero word");
        send(mk(1, 9'h041, 5'd0, 5'd0, 5'd0) | 32'h4000_0000, "R1 R7 top bits wrong");
        idle(1);
        // R8: raw moves with odd registers
        send(mk(1, 9'h001, 5'd31, 5'd0, 5'd3),  "R8 move raw");
        send(mk(1, 9'h009, 5'd5, 5'd0, 5'd7),   "R8 abs raw");
        send(mk(1, 9'h005, 5'd1, 5'd9, 5'd13),  "R8 neg raw");
        // R11: conversions
        send(mk(1, 9'h0C8, 5'd2, 5'd0, 5'd7),   "R11 int->double raw source odd");
        send(mk(1, 9'h0D3, 5'd9, 5'd0, 5'd12),  "R11 quad->int raw rd odd");
        send(mk(1, 9'h0CD, 5'd8, 5'd0, 5'd5),   "R11 single->quad");
        send(mk(1, 9'h0C7, 5'd3, 5'd0, 5'd2),   "R11 quad->single misaligned source");
        send(mk(1, 9'h0CC, 5'd1, 5'd0, 5'd0),   "R11 int->quad bad rd");
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: pending results actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule